// File: doc/BRIEF.md
# Permutation-Based Hypervector Encoder

This block converts one vector of quantized feature levels into a single encoded hypervector. A small bank of base hypervectors is held inside the block. Each element of a base vector is bipolar and is stored as one bit. Each feature's level picks one base vector from the bank. That copy is cyclically shifted by the feature's position. All the shifted copies are then added element by element, which gives a signed total for every output dimension.

The shift is never built as data. For an output dimension `j` and the feature at position `k`, the block reads base element `(j - k) mod DIM` directly, so it never stores a permuted copy of any vector. The result leaves the block as a stream of `LANES` dimensions per clock, with valid and last flags, and it takes `DIM/LANES` chunks to cover one vector. The base bank is filled through a word-wide write port while the block is idle. The bank contents stay in place across any number of encodings.

Top module: `hv_encoder`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid` and `out_last` are 0.
- R2: A write with `wr_en`=1 while the block is idle stores `wr_data[p]` as element `wr_chunk*LANES + p` of base vector `wr_level`. Stored bit 1 means +1 and bit 0 means -1. The base bank keeps these values across encodings.
- R3: Feature `k` takes its level from `in_feat[k*LVL_W +: LVL_W]`. Lane `p` of chunk `c` carries dimension `j = c*LANES + p` in `out_sum[p*SUM_W +: SUM_W]`. Its value, read as two's complement, is the sum over all features `k` of base vector `level_k` at element `(j - k) mod DIM`.
- R4: `SUM_W = clog2(NUM_FEAT+1)+1`. Every sum lies in `[-NUM_FEAT, +NUM_FEAT]`. A bank of all ones gives exactly `+NUM_FEAT` and a bank of all zeros gives exactly `-NUM_FEAT`, with no wrap.
- R5: A vector accepted at a rising edge produces `DIM/LANES` chunks on consecutive cycles, in ascending chunk order. The first chunk appears at the second rising edge after acceptance.
- R6: `out_last` is 1 only together with the final chunk of a vector, and `out_valid` is 1 whenever `out_last` is.
- R7: `in_ready` is 0 from the accepting edge until the edge that presents the final chunk. While `in_ready` is 0, `in_valid` and `in_feat` have no effect on the vector in flight. A vector held on the input is taken at the first edge where `in_ready` is 1.
- R8: A write presented while a vector is being encoded is dropped. The bank is left unchanged, both for that vector and for later ones.
- R9: A write presented in the same cycle that a vector is accepted is stored, and it already applies to that vector's sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Base bank write strobe |
| wr_level | input | LVL_W | Base vector to write |
| wr_chunk | input | CH_W | Word address inside the base vector |
| wr_data | input | LANES | Element bits, bit p goes to element wr_chunk*LANES+p |
| in_valid | input | 1 | Feature vector offered |
| in_ready | output | 1 | Block can accept a feature vector |
| in_feat | input | NUM_FEAT*LVL_W | Packed feature levels, feature 0 in the low bits |
| out_valid | output | 1 | out_sum carries a chunk |
| out_last | output | 1 | Final chunk of the vector |
| out_sum | output | LANES*SUM_W | Signed per-dimension sums, lane 0 in the low bits |

## Verification
A bank write and a vector acceptance can land on the same rising edge. A write can also arrive during encoding, when only the later vectors should reflect it. The bench provokes the first case by raising `wr_en` and `in_valid` together and then expects that vector's sums to be computed from the updated bank. It provokes the second case by writing in the first busy cycle. It then expects the current vector and a repeat of it to match the old bank exactly. Both cases are judged against an arithmetic model of rotated sums, which sits alongside an exhaustive sweep of every feature-level combination in a small configuration.

// File: rtl/hve_pkg.sv
package hve_pkg;

    // Widest group handled by one small ones-count
    localparam int GRP_MAX = 8;

    // Cyclic source index for output dimension j and feature position k
    function automatic int rot_index(input int j, input int k, input int dim);
        return (j >= k) ? (j - k) : (j - k + dim);
    endfunction

    // Ones count of a group of up to eight bits (table-like small logic)
    function automatic logic [3:0] ones8(input logic [7:0] v);
        logic [3:0] n;
        n = 4'd0;
        for (int i = 0; i < GRP_MAX; i++) begin
            n = n + {3'b000, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/hve_base_store.sv
module hve_base_store #(
    parameter int DIM     = 1000,
    parameter int LANES   = 8,
    parameter int NUM_LVL = 2,
    parameter int LVL_W   = 1,
    parameter int CH_W    = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lock_i,
    input  logic                     wr_en_i,
    input  logic [LVL_W-1:0]         wr_level_i,
    input  logic [CH_W-1:0]          wr_chunk_i,
    input  logic [LANES-1:0]         wr_data_i,
    output logic [NUM_LVL*DIM-1:0]   base_o
);
    localparam int BITS = NUM_LVL * DIM;
    localparam int AW   = (BITS > 1) ? $clog2(BITS) : 1;
    localparam int N_CH = DIM / LANES;

    logic [BITS-1:0] mem_d, mem_q;
    logic [AW-1:0]   wr_base;
    logic            wr_ok;

    always_comb begin
        wr_base = AW'(int'(wr_level_i) * DIM + int'(wr_chunk_i) * LANES);
        wr_ok   = wr_en_i && !lock_i && (int'(wr_chunk_i) < N_CH)
                  && (int'(wr_level_i) < NUM_LVL);
        mem_d   = mem_q;
        if (wr_ok) begin
            mem_d[wr_base +: LANES] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign base_o = mem_q;

    // Bank frozen while a vector is being encoded
    p_bank_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(mem_q));

endmodule

// File: rtl/hve_rotate_gather.sv
module hve_rotate_gather #(
    parameter int DIM      = 1000,
    parameter int LANES    = 8,
    parameter int NUM_FEAT = 8,
    parameter int NUM_LVL  = 2,
    parameter int LVL_W    = 1,
    parameter int CH_W     = 7
) (
    input  logic [NUM_LVL*DIM-1:0]     base_i,
    input  logic [NUM_FEAT*LVL_W-1:0]  feat_i,
    input  logic [CH_W-1:0]            chunk_i,
    output logic [LANES*NUM_FEAT-1:0]  bits_o
);
    import hve_pkg::*;

    localparam int BITS = NUM_LVL * DIM;
    localparam int AW   = (BITS > 1) ? $clog2(BITS) : 1;

    for (genvar p = 0; p < LANES; p++) begin : g_lane
        for (genvar k = 0; k < NUM_FEAT; k++) begin : g_feat
            logic [AW-1:0] addr;
            assign addr = AW'(int'(feat_i[k*LVL_W +: LVL_W]) * DIM
                              + rot_index(int'(chunk_i) * LANES + p, k, DIM));
            assign bits_o[p*NUM_FEAT + k] = base_i[addr];
        end
    end

endmodule

// File: rtl/hve_lane_sum.sv
module hve_lane_sum #(
    parameter int NUM_FEAT = 8,
    parameter int GRP      = 6,
    parameter int SUM_W    = 5
) (
    input  logic [NUM_FEAT-1:0]      bits_i,
    output logic signed [SUM_W-1:0]  sum_o
);
    import hve_pkg::*;

    localparam int N_GRP = (NUM_FEAT + GRP - 1) / GRP;
    localparam int PAD_W = N_GRP * GRP;

    logic [PAD_W-1:0] padded;
    logic [3:0]       grp_ones [N_GRP];
    logic [SUM_W-1:0] total;

    assign padded = PAD_W'(bits_i);

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign grp_ones[g] = ones8(8'(padded[g*GRP +: GRP]));
    end

    always_comb begin
        total = '0;
        for (int g = 0; g < N_GRP; g++) begin
            total = total + SUM_W'(grp_ones[g]);
        end
    end

    // +1 per set bit, -1 per clear bit
    assign sum_o = $signed((total << 1) - SUM_W'(NUM_FEAT));

endmodule

// File: rtl/hv_encoder.sv
module hv_encoder #(
    parameter int DIM      = 1000,
    parameter int LANES    = 8,
    parameter int NUM_FEAT = 8,
    parameter int NUM_LVL  = 2,
    parameter int GRP      = 6,
    localparam int LVL_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
    localparam int N_CH    = DIM / LANES,
    localparam int CH_W    = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int SUM_W   = $clog2(NUM_FEAT + 1) + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [LVL_W-1:0]            wr_level,
    input  logic [CH_W-1:0]             wr_chunk,
    input  logic [LANES-1:0]            wr_data,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [NUM_FEAT*LVL_W-1:0]   in_feat,
    output logic                        out_valid,
    output logic                        out_last,
    output logic [LANES*SUM_W-1:0]      out_sum
);
    localparam int FW = NUM_FEAT * LVL_W;
    localparam int OW = LANES * SUM_W;

    typedef struct packed {
        logic            busy;
        logic [CH_W-1:0] chunk;
        logic [FW-1:0]   feat;
        logic            out_valid;
        logic            out_last;
        logic [OW-1:0]   out_sum;
    } enc_state_t;

    enc_state_t s_d, s_q;

    logic [NUM_LVL*DIM-1:0]    base_w;
    logic [LANES*NUM_FEAT-1:0] gather_w;
    logic [OW-1:0]             lanes_w;

    hve_base_store #(
        .DIM(DIM), .LANES(LANES), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .CH_W(CH_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_i     (s_q.busy),
        .wr_en_i    (wr_en),
        .wr_level_i (wr_level),
        .wr_chunk_i (wr_chunk),
        .wr_data_i  (wr_data),
        .base_o     (base_w)
    );

    hve_rotate_gather #(
        .DIM(DIM), .LANES(LANES), .NUM_FEAT(NUM_FEAT), .NUM_LVL(NUM_LVL),
        .LVL_W(LVL_W), .CH_W(CH_W)
    ) u_gather (
        .base_i  (base_w),
        .feat_i  (s_q.feat),
        .chunk_i (s_q.chunk),
        .bits_o  (gather_w)
    );

    for (genvar p = 0; p < LANES; p++) begin : g_sum
        logic signed [SUM_W-1:0] lane_sum;
        hve_lane_sum #(
            .NUM_FEAT(NUM_FEAT), .GRP(GRP), .SUM_W(SUM_W)
        ) u_sum (
            .bits_i (gather_w[p*NUM_FEAT +: NUM_FEAT]),
            .sum_o  (lane_sum)
        );
        assign lanes_w[p*SUM_W +: SUM_W] = lane_sum;
    end

    always_comb begin
        s_d           = s_q;
        s_d.out_valid = 1'b0;
        s_d.out_last  = 1'b0;
        if (s_q.busy) begin
            s_d.out_valid = 1'b1;
            s_d.out_sum   = lanes_w;
            if (s_q.chunk == CH_W'(N_CH - 1)) begin
                s_d.out_last = 1'b1;
                s_d.busy     = 1'b0;
                s_d.chunk    = '0;
            end else begin
                s_d.chunk = s_q.chunk + 1'b1;
            end
        end else if (in_valid) begin
            s_d.busy  = 1'b1;
            s_d.chunk = '0;
            s_d.feat  = in_feat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = !s_q.busy;
    assign out_valid = s_q.out_valid;
    assign out_last  = s_q.out_last;
    assign out_sum   = s_q.out_sum;

    // Chunks of one vector leave back to back
    p_stream_gapless_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    p_last_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    p_feat_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> $stable(s_q.feat));

    p_not_ready_midstream_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> !in_ready);

    p_chunk_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.chunk) < N_CH);

    for (genvar p = 0; p < LANES; p++) begin : g_chk
        p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |->
                (int'($signed(out_sum[p*SUM_W +: SUM_W])) <= NUM_FEAT) &&
                (int'($signed(out_sum[p*SUM_W +: SUM_W])) >= -NUM_FEAT));
    end

endmodule

// File: tb/tb_hv_encoder.sv
module tb_hv_encoder;
    localparam int DIM = 12, LANES = 3, NF = 5, NL = 4, GRP = 3;
    localparam int LW = 2, NCH = 4, CW = 2, SW = 4, FW = NF * LW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [LW-1:0] wr_level = '0;
    logic [CW-1:0] wr_chunk = '0;
    logic [LANES-1:0] wr_data = '0;
    logic in_valid = 1'b0, in_ready;
    logic [FW-1:0] in_feat = '0;
    logic out_valid, out_last;
    logic [LANES*SW-1:0] out_sum;

    int checks = 0, failures = 0;
    bit done = 0;
    bit mdl [NL][DIM];

    always #10 clk = ~clk;

    hv_encoder #(.DIM(DIM), .LANES(LANES), .NUM_FEAT(NF), .NUM_LVL(NL), .GRP(GRP)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_level(wr_level),
        .wr_chunk(wr_chunk), .wr_data(wr_data), .in_valid(in_valid),
        .in_ready(in_ready), .in_feat(in_feat), .out_valid(out_valid),
        .out_last(out_last), .out_sum(out_sum));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_sum(input logic [FW-1:0] f, input int j);
        int s = 0;
        for (int k = 0; k < NF; k++) begin
            int lv = int'(f[k*LW +: LW]);
            s += mdl[lv][(j - k + DIM) % DIM] ? 1 : -1;
        end
        return s;
    endfunction

    task automatic write_word(input int lv, input int ch, input logic [LANES-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_level = LW'(lv); wr_chunk = CW'(ch); wr_data = d;
        for (int p = 0; p < LANES; p++) mdl[lv][ch*LANES + p] = d[p];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fill_bank(input int mode);
        for (int l = 0; l < NL; l++)
            for (int c = 0; c < NCH; c++) begin
                logic [LANES-1:0] d;
                for (int p = 0; p < LANES; p++) begin
                    int i = c * LANES + p;
                    d[p] = (mode == 0) ? 1'b0 : (mode == 1) ? 1'b1
                         : (((l * 7 + i * 5 + i * i) % 3) == 0);
                end
                write_word(l, c, d);
            end
    endtask

    // Offers a vector; ends at the negedge after the accepting edge
    task automatic start_vec(input logic [FW-1:0] f, input bit keep,
                             input logic [FW-1:0] nextf, input bit wr,
                             input int wl, input int wc, input logic [LANES-1:0] wd);
        @(negedge clk);
        chk(in_ready == 1'b1, "R7", "in_ready before offer", int'(in_ready), 1);
        in_valid = 1'b1; in_feat = f;
        if (wr) begin
            wr_en = 1'b1; wr_level = LW'(wl); wr_chunk = CW'(wc); wr_data = wd;
            for (int p = 0; p < LANES; p++) mdl[wl][wc*LANES + p] = wd[p];
        end
        @(negedge clk);
        wr_en = 1'b0;
        if (keep) in_feat = nextf;
        else in_valid = 1'b0;
    endtask

    // Called at the negedge after acceptance; checks every chunk
    task automatic collect_vec(input logic [FW-1:0] f, input bit busy_wr,
                               input int wl, input int wc, input logic [LANES-1:0] wd);
        chk(out_valid == 1'b0, "R5", "no chunk one cycle after accept", int'(out_valid), 0);
        chk(in_ready == 1'b0, "R7", "busy after accept", int'(in_ready), 0);
        if (busy_wr) begin
            wr_en = 1'b1; wr_level = LW'(wl); wr_chunk = CW'(wc); wr_data = wd;
        end
        for (int c = 0; c < NCH; c++) begin
            bit ok = 1;
            int bad_a = 0, bad_e = 0;
            @(negedge clk);
            wr_en = 1'b0;
            chk(out_valid == 1'b1, "R5", "chunk valid", int'(out_valid), 1);
            chk(out_last == (c == NCH - 1), "R6", "last flag", int'(out_last), int'(c == NCH - 1));
            if (c < NCH - 1)
                chk(in_ready == 1'b0, "R7", "ready low midstream", int'(in_ready), 0);
            else
                chk(in_ready == 1'b1, "R7", "ready with last", int'(in_ready), 1);
            for (int p = 0; p < LANES; p++) begin
                int a = int'($signed(out_sum[p*SW +: SW]));
                int e = exp_sum(f, c * LANES + p);
                if (a != e && ok) begin ok = 0; bad_a = a; bad_e = e; end
            end
            chk(ok, busy_wr ? "R8" : "R3", "chunk sums", bad_a, bad_e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < NL; l++) for (int i = 0; i < DIM; i++) mdl[l][i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(out_last == 1'b0, "R1", "out_last after reset", int'(out_last), 0);

        // R4 extremes: all ones then all zeros
        fill_bank(1);
        start_vec(FW'(10'h1b4), 0, '0, 0, 0, 0, '0);
        collect_vec(FW'(10'h1b4), 0, 0, 0, '0);
        chk(exp_sum(FW'(10'h1b4), 0) == NF, "R4", "model max", exp_sum(FW'(10'h1b4), 0), NF);
        fill_bank(0);
        start_vec(FW'(10'h2c9), 0, '0, 0, 0, 0, '0);
        collect_vec(FW'(10'h2c9), 0, 0, 0, '0);
        chk(exp_sum(FW'(10'h2c9), 5) == -NF, "R4", "model min", exp_sum(FW'(10'h2c9), 5), -NF);

        // R2/R3 exhaustive sweep over every level combination
        fill_bank(2);
        for (int v = 0; v < (1 << FW); v++) begin
            start_vec(FW'(v), 0, '0, 0, 0, 0, '0);
            collect_vec(FW'(v), 0, 0, 0, '0);
        end

        // R8 write during encoding dropped, then repeat shows bank intact
        start_vec(FW'(10'h0e4), 0, '0, 0, 0, 0, '0);
        collect_vec(FW'(10'h0e4), 1, 0, 0, ~{mdl[0][2], mdl[0][1], mdl[0][0]});
        start_vec(FW'(10'h0e4), 0, '0, 0, 0, 0, '0);
        collect_vec(FW'(10'h0e4), 0, 0, 0, '0);

        // R9 write in the accepting cycle applies to that vector
        start_vec(FW'(10'h000), 0, '0, 1, 0, 1,
                  ~{mdl[0][5], mdl[0][4], mdl[0][3]});
        collect_vec(FW'(10'h000), 0, 0, 0, '0);
        start_vec(FW'(10'h3ff), 0, '0, 1, 3, 3, 3'b101);
        collect_vec(FW'(10'h3ff), 0, 0, 0, '0);

        // R7 back to back: second vector held during the first
        start_vec(FW'(10'h1e2), 1, FW'(10'h32d), 0, 0, 0, '0);
        collect_vec(FW'(10'h1e2), 0, 0, 0, '0);
        @(negedge clk);
        in_valid = 1'b0;
        collect_vec(FW'(10'h32d), 0, 0, 0, '0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule